// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a 64-bit count of nanoseconds for precision time protocol use. On every rising edge of the datapath clock, while counting is enabled, it adds a programmable step held in 32.32 fixed point. A 32-bit fractional accumulator keeps the sub-nanosecond remainder, and its carry goes into the nanosecond count, so the long-run rate equals the programmed step exactly. A step of 0x0199999999 gives 1.6 ns per tick, 0x0333333333 gives 3.2 ns and 0x2000000000 gives 32 ns.

Software reaches the block through a plain 32-bit register port with single-cycle write and read strobes. Every 64-bit quantity is split into low and high words, and each has an access order that keeps it atomic. Reading the time low word freezes the high half for a later high-word read. Writing the time high word loads the whole time. Writing the step high word commits a new step. The block only applies values that software has computed. The live nanosecond count is also driven on an output so that capture logic can sample it.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the time and the fraction are zero, counting is disabled (control bit 0 reads 0), and the active step is 0x0000_0001_9999_9999 (1.6 ns).
- R2: Word addresses are 0 = control (bit 0 = count enable), 1 = time low, 2 = time high, 3 = step low, 4 = step high. Read data appears on reg_rdata in the cycle after reg_rd is sampled. Reads of addresses 5 to 7 return 0, and writes to them are ignored.
- R3: The time is loaded with T and then N ticks are counted with step S. The nanosecond count then equals floor((T*2^32 + N*S) / 2^32), modulo 2^64.
- R4: While the enable bit is 0, the nanosecond count holds its value.
- R5: A read of time low returns the low half of the time and captures its high half. A later read of time high returns that captured half, not the live value.
- R6: A write of time low only stages the word. A write of time high loads {written high, staged low} into the count at that clock edge.
- R7: A time load takes priority over the increment in the same cycle and clears the fraction.
- R8: A write of step low alone leaves the active step unchanged. A write of step high commits {written high, staged low}, and the new step is used from the next edge. Step reads return the active step.
- R9: tod_ns carries the live registered nanosecond count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock; one tick per rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| tod_ns | output | 64 | Live nanosecond count |

## Verification
- **Loads:** a load from a time high write shows on tod_ns right after the edge that samples the write.
- **Counting:** when control bit 0 is written at edge a and cleared at edge a+N, exactly N ticks are counted, at edges a+1 to a+N.
- **Reads:** read data is sampled at the falling edge after the edge that takes reg_rd, and it reflects the count from before that edge.
- **Stimulus timing:** the bench drives all stimulus on falling edges, so every expected value is tied to a known edge count.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_T_LO  = 3'd1,
    A_T_HI  = 3'd2,
    A_S_LO  = 3'd3,
    A_S_HI  = 3'd4
  } reg_addr_e;

  localparam logic [63:0] STEP_1P6NS = 64'h0000_0001_9999_9999;
endpackage

// File: rtl/ptp_step_reg.sv
module ptp_step_reg #(
  parameter int DW = 32,
  parameter logic [2*DW-1:0] STEP_INIT = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] step_q
);
  localparam int SW = 2 * DW;

  logic [DW-1:0] lo_stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_stage_q <= STEP_INIT[DW-1:0];
      step_q     <= STEP_INIT;
    end else begin
      if (wr_lo) lo_stage_q <= wdata;
      if (wr_hi) step_q <= {wdata, lo_stage_q};
    end
  end

  // R8
  lo_alone_keeps_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> $stable(step_q));

  // R8
  hi_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> step_q[SW-1:DW] == $past(wdata));
endmodule

// File: rtl/ptp_tod_core.sv
module ptp_tod_core #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_en,
  input  logic            load,
  input  logic [2*DW-1:0] load_val,
  input  logic [2*DW-1:0] step,
  output logic [2*DW-1:0] ns_q
);
  localparam int NS_W = 2 * DW;

  logic [DW-1:0]   frac_q;
  logic [DW:0]     frac_sum;
  logic [NS_W-1:0] ns_next;

  always_comb begin
    frac_sum = {1'b0, frac_q} + {1'b0, step[DW-1:0]};
    ns_next  = ns_q + {{DW{1'b0}}, step[NS_W-1:DW]}
                    + {{(NS_W-1){1'b0}}, frac_sum[DW]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q   <= '0;
      frac_q <= '0;
    end else if (load) begin
      ns_q   <= load_val;
      frac_q <= '0;
    end else if (cnt_en) begin
      ns_q   <= ns_next;
      frac_q <= frac_sum[DW-1:0];
    end
  end

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load) |=> $stable(ns_q));

  // R6
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ns_q == $past(load_val));

  // R7
  load_clears_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> frac_q == '0);

  // R3
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !load) |=>
      ((ns_q - $past(ns_q)) == {{DW{1'b0}}, $past(step[NS_W-1:DW])}) ||
      ((ns_q - $past(ns_q)) == ({{DW{1'b0}}, $past(step[NS_W-1:DW])} + 1'b1)));
endmodule

// File: rtl/ptp_reg_port.sv
module ptp_reg_port
  import ptp_tod_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [2*DW-1:0]   ns,
  input  logic [2*DW-1:0]   step,
  output logic              cnt_en,
  output logic              load,
  output logic [2*DW-1:0]   load_val,
  output logic              step_wr_lo,
  output logic              step_wr_hi
);
  localparam int NS_W = 2 * DW;

  logic [DW-1:0] t_lo_stage_q;
  logic [DW-1:0] hi_snap_q;

  always_comb begin
    load       = reg_wr && (reg_addr == A_T_HI);
    load_val   = {reg_wdata, t_lo_stage_q};
    step_wr_lo = reg_wr && (reg_addr == A_S_LO);
    step_wr_hi = reg_wr && (reg_addr == A_S_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_en       <= 1'b0;
      t_lo_stage_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL) cnt_en <= reg_wdata[0];
      if (reg_addr == A_T_LO) t_lo_stage_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      hi_snap_q <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_CTRL: reg_rdata <= {{(DW-1){1'b0}}, cnt_en};
        A_T_LO: begin
          reg_rdata <= ns[DW-1:0];
          hi_snap_q <= ns[NS_W-1:DW];
        end
        A_T_HI: reg_rdata <= hi_snap_q;
        A_S_LO: reg_rdata <= step[DW-1:0];
        A_S_HI: reg_rdata <= step[NS_W-1:DW];
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R5
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_T_LO) |=> hi_snap_q == $past(ns[NS_W-1:DW]));

  // R5
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr == A_T_LO) |=> $stable(hi_snap_q));

  // R2
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr > A_S_HI) |=> reg_rdata == '0);
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptp_tod_pkg::*;
#(
  parameter int DW = 32,
  parameter logic [2*DW-1:0] STEP_INIT = STEP_1P6NS[2*DW-1:0]
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [2*DW-1:0]   tod_ns
);
  localparam int NS_W = 2 * DW;

  logic            cnt_en;
  logic            load;
  logic [NS_W-1:0] load_val;
  logic            step_wr_lo;
  logic            step_wr_hi;
  logic [NS_W-1:0] step;
  logic [NS_W-1:0] ns;

  ptp_reg_port #(.DW(DW)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ns         (ns),
    .step       (step),
    .cnt_en     (cnt_en),
    .load       (load),
    .load_val   (load_val),
    .step_wr_lo (step_wr_lo),
    .step_wr_hi (step_wr_hi)
  );

  ptp_step_reg #(.DW(DW), .STEP_INIT(STEP_INIT)) u_step (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_lo  (step_wr_lo),
    .wr_hi  (step_wr_hi),
    .wdata  (reg_wdata),
    .step_q (step)
  );

  ptp_tod_core #(.DW(DW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .load     (load),
    .load_val (load_val),
    .step     (step),
    .ns_q     (ns)
  );

  assign tod_ns = ns;
endmodule

// File: tb/ptp_tod_counter_tb_top.sv
module ptp_tod_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] tod_ns;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ptp_tod_counter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tod_ns(tod_ns)
  );

  localparam int NV = 4;
  localparam logic [63:0] V_T0 [NV] = '{64'h0, 64'h0000_0000_FFFF_FFF0,
                                         64'h1234_5678_9ABC_DEF0, 64'h64};
  localparam logic [63:0] V_ST [NV] = '{64'h01_9999_9999, 64'h03_3333_3333,
                                         64'h20_0000_0000, 64'h00_8000_0000};
  localparam int V_N [NV] = '{10, 7, 5, 9};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [63:0] expect_ns(input logic [63:0] t0, input logic [63:0] st, input int n);
    logic [95:0] tot;
    tot = {t0, 32'h0} + 96'(st) * 96'(n);
    return tot[95:32];
  endfunction

  task automatic load_time(input logic [63:0] t);
    wr(3'd1, t[31:0]);
    wr(3'd2, t[63:32]);
  endtask

  task automatic set_step(input logic [63:0] s);
    wr(3'd3, s[31:0]);
    wr(3'd4, s[63:32]);
  endtask

  task automatic run_ticks(input int n);
    wr(3'd0, 32'h1);
    repeat (n - 1) @(negedge clk);
    wr(3'd0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, lo;
    logic [63:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R9 reset state
    chk("R1 R9 reset time", tod_ns, 64'h0);
    rd(3'd0, d); chk("R1 R2 ctrl reset", 64'(d), 64'h0);
    rd(3'd3, d); chk("R1 step lo reset", 64'(d), 64'h9999_9999);
    rd(3'd4, d); chk("R1 step hi reset", 64'(d), 64'h1);
    rd(3'd6, d); chk("R2 unmapped read", 64'(d), 64'h0);

    // R3 vector table
    for (int i = 0; i < NV; i++) begin
      set_step(V_ST[i]);
      load_time(V_T0[i]);
      run_ticks(V_N[i]);
      chk("R3 R9 tod_ns after ticks", tod_ns, expect_ns(V_T0[i], V_ST[i], V_N[i]));
      rd(3'd1, lo);
      rd(3'd2, d);
      chk("R3 R5 time via registers", {d, lo}, expect_ns(V_T0[i], V_ST[i], V_N[i]));
    end

    // R6 low write stages only, high write loads
    hold = tod_ns;
    wr(3'd1, 32'h0000_DEAD);
    chk("R6 low write no load", tod_ns, hold);
    wr(3'd2, 32'h77);
    chk("R6 high write loads", tod_ns, 64'h0000_0077_0000_DEAD);

    // R4 disabled holds
    wr(3'd7, 32'h1);
    repeat (20) @(negedge clk);
    chk("R4 R2 hold while disabled", tod_ns, 64'h0000_0077_0000_DEAD);

    // R8 step low alone is not used
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, d); chk("R8 step lo not committed", 64'(d), 64'h8000_0000);
    load_time(64'h0);
    run_ticks(8);
    chk("R8 old step still used", tod_ns, 64'h4);
    wr(3'd4, 32'h0);
    rd(3'd3, d); chk("R8 step commit lo", 64'(d), 64'hFFFF_FFFF);

    // R7 load beats increment, fraction cleared
    set_step(64'h01_9999_9999);
    wr(3'd0, 32'h1);
    repeat (3) @(negedge clk);
    wr(3'd1, 32'h1000);
    wr(3'd2, 32'h0);
    chk("R7 load while counting", tod_ns, 64'h1000);
    repeat (5) @(negedge clk);
    chk("R7 fraction cleared on load", tod_ns, expect_ns(64'h1000, 64'h01_9999_9999, 5));
    wr(3'd0, 32'h0);

    // R5 snapshot high word
    set_step(64'h20_0000_0000);
    load_time(64'h0000_0005_FFFF_FF00);
    wr(3'd0, 32'h1);
    rd(3'd1, lo);
    chk("R5 low read value", 64'(lo), 64'hFFFF_FF00);
    repeat (10) @(negedge clk);
    chk("R9 live high moved", 64'(tod_ns[63:32]), 64'h6);
    rd(3'd2, d);
    chk("R5 high from snapshot", 64'(d), 64'h5);
    wr(3'd0, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule